// File: doc/BRIEF.md
# Address-Latched Flash Read Sequencer

This block runs single read transfers to external flash-style devices that capture the address on a one-cycle address-valid strobe. A request carries a 9-bit address and a chip-select index. It is taken on a valid/ready handshake. The sequencer then asserts the chosen select line, pulses the address strobe, and drives the address for one cycle. It drives the address for a second cycle when address hold is enabled. Output enable comes on after a programmed delay. The 16-bit data bus is sampled on the last output-enable cycle and the captured word is returned as a one-cycle response.

Three configuration inputs set the timing. The first is an address-hold enable. The second is a 2-bit gap counted from the strobe cycle to output enable. The third is a 4-bit first-segment length counted from the first select cycle to output enable. Output enable starts when the longer of the two counts has elapsed, and never in the strobe cycle itself. The sequencer always places one quiet bus cycle between transfers.

Top module: `advrd_seq`

## Requirements
- R1: After reset, `req_ready` is 1. All `bus_cs_n` lines, `bus_adv_n` and `bus_oe_n` are 1, `bus_addr` is 0 and `rsp_valid` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Index i (0 to 5) selects line `bus_cs_n[i]`. That line is driven low from the next cycle ("cycle 0") through the last output-enable cycle. `bus_adv_n` is low in cycle 0 only.
- R3: `bus_addr` carries the request address in cycle 0. It also carries the address in cycle 1 when `cfg_addr_hold` is 1. In every other cycle it is 0.
- R4: `bus_oe_n` first goes low in cycle K. K is the larger of `cfg_adv_oe` and `cfg_rd_hold`, raised to 1 when both are 0.
- R5: `bus_oe_n` stays low for exactly two cycles (K and K+1). The select line returns high in the same cycle that `bus_oe_n` does.
- R6: `bus_din` is captured at the rising edge that ends cycle K+1. `rsp_valid` is high for exactly cycle K+2, and `rsp_data` holds the captured word from then until the next capture.
- R7: Cycle K+2 is idle, with all strobes high and `req_ready` low. `req_ready` is low from cycle 0 through K+2, so `req_valid` is ignored during that time. `req_ready` returns to 1 in cycle K+3.
- R8: The address, the select index and all three configuration inputs are sampled at acceptance. Changes to them during the transfer have no effect on it.
- R9: An index of 6 or 7 asserts no select line. The strobe, address and output-enable timing still run as for a valid index.
- R10: At most one select line is low at any time, and `bus_oe_n` is never low in a cycle where `bus_adv_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 9 | Read address |
| req_cs | input | 3 | Select index |
| cfg_addr_hold | input | 1 | Drive the address for one extra cycle |
| cfg_adv_oe | input | 2 | Cycles from strobe cycle to output enable |
| cfg_rd_hold | input | 4 | Cycles from first select cycle to output enable |
| bus_cs_n | output | 6 | Active-low select lines |
| bus_adv_n | output | 1 | Active-low address-valid strobe |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_addr | output | 9 | External address lines |
| bus_din | input | 16 | External data bus |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Captured read data |

## Verification
The bench targets several corner cases. When both counts are 0, a design that skipped the floor would raise output enable alongside the strobe. When the two counts differ, either one may be the larger; a design that honoured only one of them would open output enable early. The maximum first segment of 15 checks that the phase counter is wide enough, since a narrow counter would wrap and never finish. The bench drives correct data only during the final output-enable cycle, so capturing a cycle early returns the inverted word. The bench also changes the configuration and request inputs right after acceptance, and holds `req_valid` high during a transfer. A design that used live inputs, or that accepted during the quiet cycle, would show altered strobes or a second strobe.

// File: rtl/advrd_pkg.sv
package advrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_GAP  = 2'd2
  } advrd_st_e;

  // Phase index of the first output-enable cycle: larger of the two
  // counts, never earlier than the cycle after the strobe.
  function automatic logic [7:0] oe_start(input logic [7:0] gap,
                                          input logic [7:0] hold);
    logic [7:0] m;
    m = (hold > gap) ? hold : gap;
    if (m == 8'd0) m = 8'd1;
    return m;
  endfunction

endpackage

// File: rtl/advrd_cs_dec.sv
module advrd_cs_dec #(
  parameter int N_CS = 6,
  parameter int CSW  = 3
) (
  input  logic            en,
  input  logic [CSW-1:0]  idx,
  output logic [N_CS-1:0] sel
);
  for (genvar gi = 0; gi < N_CS; gi++) begin : g_line
    assign sel[gi] = en && (idx == CSW'(gi));
  end
endmodule

// File: rtl/advrd_phase.sv
module advrd_phase
  import advrd_pkg::*;
#(
  parameter int GAP_W  = 2,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              addr_hold,
  input  logic [GAP_W-1:0]  gap,
  input  logic [HOLD_W-1:0] hold,
  output logic              ready,
  output logic              act,
  output logic              adv,
  output logic              addr_en,
  output logic              oe,
  output logic              last
);
  localparam int MAXW = (HOLD_W > GAP_W) ? HOLD_W : GAP_W;
  localparam int CNTW = MAXW + 1;

  advrd_st_e        st;
  logic [CNTW-1:0]  cnt;
  logic [CNTW-1:0]  k_r;
  logic             ah_r;

  assign ready   = (st == ST_IDLE);
  assign act     = (st == ST_ACT);
  assign last    = act && (cnt == k_r + CNTW'(1));
  assign adv     = act && (cnt == '0);
  assign addr_en = act && ((cnt == '0) || (ah_r && (cnt == CNTW'(1))));
  assign oe      = act && ((cnt == k_r) || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      k_r  <= '0;
      ah_r <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_ACT;
          cnt  <= '0;
          k_r  <= CNTW'(oe_start(8'(gap), 8'(hold)));
          ah_r <= addr_hold;
        end
        ST_ACT: begin
          if (last) st <= ST_GAP;
          else      cnt <= cnt + CNTW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/advrd_seq.sv
module advrd_seq #(
  parameter int N_CS   = 6,
  parameter int AW     = 9,
  parameter int DW     = 16,
  parameter int GAP_W  = 2,
  parameter int HOLD_W = 4,
  parameter int CSW    = $clog2(N_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [CSW-1:0]    req_cs,
  input  logic              cfg_addr_hold,
  input  logic [GAP_W-1:0]  cfg_adv_oe,
  input  logic [HOLD_W-1:0] cfg_rd_hold,
  output logic [N_CS-1:0]   bus_cs_n,
  output logic              bus_adv_n,
  output logic              bus_oe_n,
  output logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_din,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data
);
  logic            accept_w, act_w, adv_w, addr_en_w, oe_w, last_w, ready_w;
  logic [AW-1:0]   addr_r;
  logic [CSW-1:0]  cs_r;
  logic [N_CS-1:0] sel_w;

  assign accept_w  = req_valid && ready_w;
  assign req_ready = ready_w;

  advrd_phase #(.GAP_W(GAP_W), .HOLD_W(HOLD_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(accept_w),
    .addr_hold(cfg_addr_hold), .gap(cfg_adv_oe), .hold(cfg_rd_hold),
    .ready(ready_w), .act(act_w), .adv(adv_w), .addr_en(addr_en_w),
    .oe(oe_w), .last(last_w)
  );

  advrd_cs_dec #(.N_CS(N_CS), .CSW(CSW)) u_dec (
    .en(act_w), .idx(cs_r), .sel(sel_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r    <= '0;
      cs_r      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (accept_w) begin
        addr_r <= req_addr;
        cs_r   <= req_cs;
      end
      rsp_valid <= last_w;
      if (last_w) rsp_data <= bus_din;
    end
  end

  assign bus_cs_n  = ~sel_w;
  assign bus_adv_n = ~adv_w;
  assign bus_oe_n  = ~oe_w;
  assign bus_addr  = addr_en_w ? addr_r : '0;
endmodule

// File: rtl/advrd_chk.sv
module advrd_chk #(
  parameter int N_CS = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic [N_CS-1:0] bus_cs_n,
  input logic            bus_adv_n,
  input logic            bus_oe_n,
  input logic            rsp_valid,
  input logic            busy
);
  // R2
  adv_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |=> bus_adv_n);
  // R2
  adv_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |-> busy);
  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  // R10
  oe_not_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> bus_adv_n);
  // R5
  oe_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe_n) |=> !bus_oe_n);
  // R6
  rsp_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!bus_oe_n));
  // R7
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_adv_n && bus_oe_n && (&bus_cs_n)));
  // R7
  rsp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && bus_oe_n));
endmodule

bind advrd_seq advrd_chk #(.N_CS(N_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_cs_n(bus_cs_n),
  .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n), .rsp_valid(rsp_valid),
  .busy(act_w)
);

// File: tb/tb_advrd_seq.sv
`timescale 1ns/1ps
module tb_advrd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [8:0]  req_addr = '0;
  logic [2:0]  req_cs = '0;
  logic        cfg_addr_hold = 1'b0;
  logic [1:0]  cfg_adv_oe = '0;
  logic [3:0]  cfg_rd_hold = '0;
  logic [5:0]  bus_cs_n;
  logic        bus_adv_n, bus_oe_n, rsp_valid;
  logic [8:0]  bus_addr;
  logic [15:0] bus_din = '0;
  logic [15:0] rsp_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  advrd_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cs(req_cs), .cfg_addr_hold(cfg_addr_hold),
    .cfg_adv_oe(cfg_adv_oe), .cfg_rd_hold(cfg_rd_hold), .bus_cs_n(bus_cs_n),
    .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n), .bus_addr(bus_addr),
    .bus_din(bus_din), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R1: reset state, observed over several idle cycles
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
      chk(bus_cs_n == 6'h3f, "R1", "cs_n", int'(bus_cs_n), 'h3f);
      chk(bus_adv_n && bus_oe_n, "R1", "adv_n/oe_n",
          int'({bus_adv_n, bus_oe_n}), 3);
      chk(bus_addr == '0, "R1", "addr", int'(bus_addr), 0);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    end
  endtask

  // One read; inputs are scrambled after acceptance (R8) and, if noisy,
  // req_valid is held high during the transfer (R7).
  task automatic t_read(input logic [8:0] a, input int cs, input bit ah,
                        input int g, input int h, input logic [15:0] d,
                        input bit noisy);
    int k;
    logic [5:0] exp_cs;
    k = (h > g) ? h : g;
    if (k == 0) k = 1;
    exp_cs = (cs < 6) ? ~(6'd1 << cs) : 6'h3f;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready before req", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_cs = 3'(cs);
    cfg_addr_hold = ah; cfg_adv_oe = 2'(g); cfg_rd_hold = 4'(h);
    for (int i = 0; i <= k + 1; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_valid = noisy; req_addr = ~a; req_cs = 3'(cs + 1);
        cfg_addr_hold = ~ah; cfg_adv_oe = ~2'(g); cfg_rd_hold = ~4'(h);
      end
      chk(bus_cs_n == exp_cs, (cs < 6) ? "R2" : "R9", "cs_n",
          int'(bus_cs_n), int'(exp_cs));
      chk(bus_adv_n == (i != 0), "R2", "adv_n", int'(bus_adv_n),
          int'(i != 0));
      chk(bus_oe_n == !(i == k || i == k + 1), "R4", "oe_n",
          int'(bus_oe_n), int'(!(i == k || i == k + 1)));
      chk(bus_addr == (((i == 0) || (ah && i == 1)) ? a : 9'd0), "R3",
          "addr", int'(bus_addr),
          int'(((i == 0) || (ah && i == 1)) ? a : 9'd0));
      chk(req_ready == 1'b0, "R7", "ready busy", int'(req_ready), 0);
      bus_din = (i == k + 1) ? d : ~d;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_cs_n == 6'h3f && bus_oe_n && bus_adv_n, "R5", "strobes idle",
        int'({bus_cs_n, bus_oe_n, bus_adv_n}), 'hff);
    chk(rsp_valid == 1'b1, "R6", "rsp_valid", int'(rsp_valid), 1);
    chk(rsp_data == d, "R6", "rsp_data", int'(rsp_data), int'(d));
    chk(req_ready == 1'b0, "R7", "ready gap", int'(req_ready), 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready back", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R6", "rsp pulse end", int'(rsp_valid), 0);
    chk(rsp_data == d, "R6", "rsp_data held", int'(rsp_data), int'(d));
    chk(bus_adv_n == 1'b1, "R7", "no second strobe", int'(bus_adv_n), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read(9'h1a5, 0, 1'b0, 0, 0, 16'hbeef, 1'b0);  // R4 floor of 1
    t_read(9'h0f3, 5, 1'b1, 2, 0, 16'h1234, 1'b0);  // R3 hold, gap wins
    t_read(9'h100, 3, 1'b0, 1, 7, 16'h55aa, 1'b1);  // R4 hold wins, R7
    t_read(9'h1ff, 2, 1'b1, 3, 15, 16'hc3c3, 1'b0); // R4 max count
    t_read(9'h002, 1, 1'b0, 3, 2, 16'h0f0f, 1'b1);  // R8 gap wins
    t_read(9'h0aa, 6, 1'b1, 1, 3, 16'h9999, 1'b0);  // R9 out of range
    t_read(9'h155, 4, 1'b0, 0, 1, 16'h7e81, 1'b0);  // R10 OE after ADV
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule